// File: doc/BRIEF.md
# Tone Half-Period Measurement Counter

The block measures the frequency of a received tone that has already been squared into a one-bit logic signal. It waits for the first transition of that signal. It then opens a gate of fixed length and counts the whole half-periods of the input that fit in the gate, giving N. It also counts the measuring-clock units that pass after the last counted transition until the gate closes, giving R. In units, the gate length equals N half-periods plus R, so a host can compute the input frequency from the pair. When a measurement is valid, the pair is published as one word, with N in the upper field and R in the lower field, and a one-cycle completion strobe is raised. When a measurement is not usable, a no-tone strobe is raised instead and the published word does not change.

Timing runs on a tick input that pulses at the measuring-clock base rate. In the high, extended and reserved band codes, one unit is one tick. In the mid band, one unit is two ticks, so the gate lasts twice as long. The result leaves on a valid/ready port. The word is held stable while valid is high and ready is low. Valid falls in the cycle after a cycle with ready high. A new result always overwrites the held word, so a slow consumer loses older results, not newer ones. The no-tone and completion strobes are plain pulses that are not held.

Top module: `tone_meas_counter`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `done_o`, `notone_o` and `res_valid` are low.
- R2: Take the edge cycle as the clock edge at which the synchronised input is first seen to change. The gate is then GATE_UNITS units long. N is the number of further input transitions within the gate, including one on its final unit. R is the number of units counted after the last such transition. So N*P + R = GATE_UNITS for an input with half-period P units.
- R3: Band code 2'b01 (mid) makes one unit equal to two ticks. Codes 2'b00, 2'b10 and 2'b11 make one unit equal to one tick.
- R4: `res_data` holds N in bits [N_W+R_W-1:R_W] and R in bits [R_W-1:0].
- R5: A measurement with N of 1 or more that fits in N_W bits pulses `done_o` for one cycle and loads `res_data`, with `res_valid` high in that same cycle.
- R6: A gate that ends with N equal to zero, or with more than 2^N_W-1 transitions, pulses `notone_o` instead of `done_o`, and leaves `res_valid` and `res_data` unchanged.
- R7: If no input transition arrives within GATE_UNITS units of waiting, `notone_o` pulses and waiting restarts.
- R8: While `res_valid` is high and `res_ready` is low, `res_data` and `res_valid` hold. After a cycle with `res_ready` high and no new result, `res_valid` is low.
- R9: With `tick_in` held low, no gate ever closes and neither strobe pulses.
- R10: An input change driven before clock edge k is seen at edge k+2. The strobe for that measurement registers at edge k+2+GATE_UNITS units.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sig_in | input | 1 | Squared received tone, asynchronous |
| tick_in | input | 1 | Measuring-clock base tick, one cycle wide |
| band_sel | input | 2 | Band code: 00 high, 01 mid, 10 extended, 11 treated as high |
| done_o | output | 1 | One-cycle pulse on a valid measurement |
| notone_o | output | 1 | One-cycle pulse on an aborted measurement or a wait timeout |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer accepts the result word |
| res_data | output | N_W+R_W | Result word: N in the upper field, R in the lower field |

## Verification
The input passes through two synchroniser stages, so a change driven before edge k takes effect at edge k+2. With the tick held high, a strobe then appears GATE_UNITS cycles later in the one-tick bands and twice that many in the mid band. The bench drives the input and samples the outputs on falling edges. It records the falling-edge index at which the first strobe is seen and compares it with GATE_UNITS+3, or 2*GATE_UNITS+3 for the mid band. At that same sample it compares the word with floor(G/P) and G mod P, computed in units. Hold and ready behaviour is checked one falling edge after each change of `res_ready`.

// File: rtl/tfm_pkg.sv
package tfm_pkg;
  typedef enum logic [1:0] {
    BAND_HIGH = 2'b00,
    BAND_MID  = 2'b01,
    BAND_EXT  = 2'b10,
    BAND_RSV  = 2'b11
  } band_e;

  typedef enum logic {
    ST_WAIT = 1'b0,
    ST_RUN  = 1'b1
  } meas_st_e;

  function automatic logic band_is_slow(input logic [1:0] b);
    return band_e'(b) == BAND_MID;
  endfunction
endpackage

// File: rtl/tfm_edge_sync.sv
module tfm_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic toggle
);
  localparam int LEN = STAGES + 1;
  logic [LEN-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[LEN-2:0], sig_in};
  end

  // compare the last synchronised stage with its delayed copy
  assign toggle = chain[LEN-2] ^ chain[LEN-1];
endmodule

// File: rtl/tfm_unit_gen.sv
module tfm_unit_gen
  import tfm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_in,
  input  logic [1:0] band_sel,
  input  logic       restart,
  output logic       unit
);
  logic phase;
  logic slow;

  assign slow = band_is_slow(band_sel);
  assign unit = tick_in & (slow ? phase : 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart)  phase <= 1'b0;
    else if (tick_in && slow) phase <= ~phase;
  end

  assert_unit_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (unit && slow && !restart) |=> !(unit && slow));
endmodule

// File: rtl/tfm_meas_core.sv
module tfm_meas_core
  import tfm_pkg::*;
#(
  parameter int GATE_UNITS = 511,
  parameter int N_W = 8,
  parameter int R_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           toggle,
  input  logic           unit,
  output logic           restart,
  output logic           fin_ok,
  output logic [N_W-1:0] fin_n,
  output logic [R_W-1:0] fin_r,
  output logic           done_o,
  output logic           notone_o
);
  localparam int CNT_W = $clog2(GATE_UNITS);
  localparam int RC_W  = $clog2(GATE_UNITS + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(GATE_UNITS - 1);

  meas_st_e       st;
  logic [CNT_W-1:0] gcnt;
  logic [N_W-1:0] n_q, n_nx;
  logic           ovf_q, ovf_nx;
  logic [RC_W-1:0] r_q, r_nx;
  logic           gate_end, wait_to, fin_bad;

  always_comb begin
    n_nx     = toggle ? N_W'(n_q + 1'b1) : n_q;
    ovf_nx   = ovf_q | (toggle && (n_q == '1));
    r_nx     = toggle ? '0 : (unit ? RC_W'(r_q + 1'b1) : r_q);
    gate_end = (st == ST_RUN) && unit && (gcnt == LAST);
    wait_to  = (st == ST_WAIT) && !toggle && unit && (gcnt == LAST);
    restart  = (st == ST_WAIT) && toggle;
    fin_ok   = gate_end && !ovf_nx && (n_nx != '0);
    fin_bad  = gate_end && !fin_ok;
    fin_n    = n_nx;
    fin_r    = R_W'(r_nx);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= ST_WAIT; gcnt <= '0; n_q <= '0; ovf_q <= 1'b0; r_q <= '0;
      done_o <= 1'b0; notone_o <= 1'b0;
    end else begin
      done_o   <= fin_ok;
      notone_o <= fin_bad | wait_to;
      if (st == ST_WAIT) begin
        if (toggle) begin
          st <= ST_RUN; gcnt <= '0; n_q <= '0; ovf_q <= 1'b0; r_q <= '0;
        end else if (unit) begin
          gcnt <= wait_to ? '0 : CNT_W'(gcnt + 1'b1);
        end
      end else begin
        n_q <= n_nx; ovf_q <= ovf_nx; r_q <= r_nx;
        if (gate_end) begin
          st <= ST_WAIT; gcnt <= '0;
        end else if (unit) begin
          gcnt <= CNT_W'(gcnt + 1'b1);
        end
      end
    end
  end

  assert_gate_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gcnt <= LAST);
  assert_residual_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fin_ok |-> (int'(r_nx) < (1 << R_W)));
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
endmodule

// File: rtl/tfm_result_port.sv
module tfm_result_port #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         ready,
  output logic         valid,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> (valid && $stable(data)));
endmodule

// File: rtl/tone_meas_counter.sv
module tone_meas_counter
  import tfm_pkg::*;
#(
  parameter int GATE_UNITS = 511,
  parameter int N_W = 8,
  parameter int R_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sig_in,
  input  logic               tick_in,
  input  logic [1:0]         band_sel,
  output logic               done_o,
  output logic               notone_o,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [N_W+R_W-1:0] res_data
);
  localparam int RES_W = N_W + R_W;

  logic           toggle, unit, restart, fin_ok;
  logic [N_W-1:0] fin_n;
  logic [R_W-1:0] fin_r;

  tfm_edge_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .toggle(toggle)
  );

  tfm_unit_gen u_unit (
    .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .band_sel(band_sel),
    .restart(restart), .unit(unit)
  );

  tfm_meas_core #(.GATE_UNITS(GATE_UNITS), .N_W(N_W), .R_W(R_W)) u_core (
    .clk(clk), .rst_n(rst_n), .toggle(toggle), .unit(unit),
    .restart(restart), .fin_ok(fin_ok), .fin_n(fin_n), .fin_r(fin_r),
    .done_o(done_o), .notone_o(notone_o)
  );

  tfm_result_port #(.W(RES_W)) u_port (
    .clk(clk), .rst_n(rst_n), .load(fin_ok), .load_data({fin_n, fin_r}),
    .ready(res_ready), .valid(res_valid), .data(res_data)
  );

  assert_done_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> res_valid);
  assert_done_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (res_data[R_W +: N_W] != '0));
endmodule

// File: tb/tb_tone_meas_counter.sv
`timescale 1ns/1ps
module tb_tone_meas_counter;
  localparam int G  = 40;
  localparam int NW = 5;
  localparam int RW = 5;
  localparam int NMAX = (1 << NW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sig = 1'b0;
  logic tick = 1'b1;
  logic [1:0] band = 2'b00;
  logic ready = 1'b0;
  logic done, notone, valid;
  logic [NW+RW-1:0] data;

  int total = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tone_meas_counter #(.GATE_UNITS(G), .N_W(NW), .R_W(RW)) dut (
    .clk(clk), .rst_n(rst_n), .sig_in(sig), .tick_in(tick), .band_sel(band),
    .done_o(done), .notone_o(notone), .res_valid(valid), .res_ready(ready),
    .res_data(data)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sig = 1'b0;
    ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive a toggling input with half-period p cycles; returns event kind
  // (1 done, 2 notone, 3 both) and the falling-edge index where it appeared.
  task automatic run_toggle(input int p, input int limit, input bit stop_after,
                            output int kind, output int at);
    kind = 0;
    at = -1;
    for (int c = 0; c < limit; c++) begin
      @(negedge clk);
      if (kind == 0 && (done || notone)) begin
        kind = (done ? 1 : 0) + (notone ? 2 : 0);
        at = c;
        if (stop_after) break;
      end
      if (c % p == 0) sig = ~sig;
    end
  endtask

  task automatic one_case(input logic [1:0] b, input int p, input string req);
    int units, en, er, lat, kind, at;
    bit ok;
    band = b;
    do_reset();
    units = (b == 2'b01) ? p / 2 : p;
    lat   = (b == 2'b01) ? 2 * G + 3 : G + 3;
    en = G / units;
    er = G % units;
    ok = (en >= 1) && (en <= NMAX);
    run_toggle(p, lat + 8, 1'b1, kind, at);
    check_eq({req, " R10 latency"}, at, lat);
    if (ok) begin
      check_eq({req, " R5 done kind"}, kind, 1);
      check_eq({req, " R5 valid"}, int'(valid), 1);
      check_eq({req, " R2/R4 N field"}, int'(data[RW +: NW]), en);
      check_eq({req, " R2/R4 R field"}, int'(data[RW-1:0]), er);
    end else begin
      check_eq({req, " R6 notone kind"}, kind, 2);
      check_eq({req, " R6 valid unchanged"}, int'(valid), 0);
    end
  endtask

  initial begin
    int kind, at;
    logic [NW+RW-1:0] held;
    bit seen_notone;

    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check_eq("R1 done in reset", int'(done), 0);
    check_eq("R1 notone in reset", int'(notone), 0);
    check_eq("R1 valid in reset", int'(valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_eq("R1 valid after reset", int'(valid), 0);
    check_eq("R1 done after reset", int'(done), 0);

    // R2 R6 R10: high band sweep over half-periods (covers overflow and N=0)
    for (int p = 1; p <= 44; p++) one_case(2'b00, p, "R2 high");
    // R3: extended and reserved codes behave as one-tick units
    for (int p = 1; p <= 44; p += 3) one_case(2'b10, p, "R3 ext");
    for (int p = 2; p <= 44; p += 7) one_case(2'b11, p, "R3 rsv");
    // R3: mid band, two ticks per unit
    for (int p = 2; p <= 46; p += 2) one_case(2'b01, p, "R3 mid");

    // R7: no input transition during waiting
    band = 2'b00;
    do_reset();
    seen_notone = 1'b0;
    for (int c = 0; c < G + 6; c++) begin
      @(negedge clk);
      if (notone) seen_notone = 1'b1;
      check_eq("R7 no done while idle", int'(done), 0);
    end
    check_eq("R7 wait timeout notone", int'(seen_notone), 1);
    check_eq("R7 valid stays low", int'(valid), 0);

    // R8 R6: hold under back-pressure, then accept; P=7 gives N=5 R=5
    do_reset();
    run_toggle(7, G + 8, 1'b1, kind, at);
    check_eq("R8 first result done", kind, 1);
    held = data;
    check_eq("R8 held word", int'(held), (5 << RW) | 5);
    seen_notone = 1'b0;
    for (int c = 0; c < 2 * G + 6; c++) begin
      @(negedge clk);
      if (notone) seen_notone = 1'b1;
      check_eq("R8 valid held", int'(valid), 1);
      check_eq("R8 data held", int'(data), int'(held));
    end
    check_eq("R6 timeout leaves result", int'(seen_notone), 1);
    ready = 1'b1;
    @(negedge clk);
    ready = 1'b0;
    check_eq("R8 valid drops after ready", int'(valid), 0);

    // R9: tick low freezes the gate
    tick = 1'b0;
    do_reset();
    run_toggle(3, 4 * G, 1'b0, kind, at);
    check_eq("R9 no strobe without tick", kind, 0);
    tick = 1'b1;

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R10 watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", total, fails);
      $finish;
    end
  end
endmodule